// File: doc/BRIEF.md
# Key-Guarded Pipelined Register Memory

This block holds a window of 28-bit registers behind a simple synchronous bus with address, write data, write enable and read enable. Reads of the window are always served from storage. Writes into the window pass through a two-stage write pipeline. A value reaches storage only when a later accepted window write pushes it out of the last stage. Software therefore repeats the final write of a batch twice.

Software can lock the window. A lock is a two-write sequence: a key byte written to a key address, then a mode byte written to a control address. While the lock is set, every write into the window is dropped. Dropped writes leave the pipeline exactly as it was.

The key detector is a two-state machine:
- **KEY_IDLE**: moves to **KEY_ARMED** on a write of 0xAD to the key address.
- **KEY_ARMED**: stays armed on another 0xAD write to the key address. It returns to KEY_IDLE on any other bus write. When that write goes to the control address, it may also change the lock.

Top module: `keyreg_ram`

## Requirements
- R1: After reset, every window address (0x4380 to 0x43BE) reads 0 and `lock_on` is 0.
- R2: A write whose data bits [7:0] are 0x80 to control address 0xE7E3, made while KEY_ARMED, sets `lock_on` from the next cycle. The machine is KEY_ARMED only when the bus write just before was 0xAD (data bits [7:0]) to key address 0xE7FE.
- R3: A write of 0x00 (data bits [7:0]) to 0xE7E3, made while KEY_ARMED, clears `lock_on` from the next cycle.
- R4: Any bus write other than the key write disarms the detector. A control write made while KEY_IDLE leaves `lock_on` unchanged.
- R5: A control write with any other data byte leaves `lock_on` unchanged and disarms the detector.
- R6: While `lock_on` is 1, window writes change neither storage nor the pipeline.
- R7: A read returns its data on `rd_data` one cycle after `rd_en`, whatever the lock state. `rd_data` holds its value while `rd_en` is low.
- R8: An accepted window write reaches storage at the second later accepted window write.
- R9: A read of an address whose write is still in the pipeline returns the previously stored value.
- R10: A read of an address outside the window returns 0.
- R11: Writes to addresses outside the window change neither storage nor the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 28 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 28 | Registered read data |
| lock_on | output | 1 | Window write lock state |

## Verification
`lock_on` changes on the clock edge that samples the completing control write, so the bench checks it at the following falling edge. `rd_data` is registered from the read strobe and is sampled one falling edge after the read is driven. A committed value becomes visible to a read issued after the edge of the second later accepted write. The bench model advances its own pipeline at every accepted write and computes each expected read from that model before the read's edge.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;
    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;
endpackage

// File: rtl/key_detect.sv
module key_detect
    import keyreg_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'hE7FE,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hE7E3,
    parameter logic [7:0]      KEY_CODE  = 8'hAD,
    parameter logic [7:0]      ON_CODE   = 8'h80,
    parameter logic [7:0]      OFF_CODE  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wbyte,
    output logic              lock
);
    key_state_e state, state_nxt;
    logic       key_hit;
    logic       ctrl_hit;

    assign key_hit  = (addr == KEY_ADDR) && (wbyte == KEY_CODE);
    assign ctrl_hit = (addr == CTRL_ADDR);

    always_comb begin
        state_nxt = state;
        unique case (state)
            KEY_IDLE:  if (we && key_hit) state_nxt = KEY_ARMED;
            KEY_ARMED: if (we) state_nxt = key_hit ? KEY_ARMED : KEY_IDLE;
            default:   state_nxt = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
        end else if (state == KEY_ARMED && we && ctrl_hit) begin
            if (wbyte == ON_CODE)       lock <= 1'b1;
            else if (wbyte == OFF_CODE) lock <= 1'b0;
        end
    end

    // R2
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KEY_ARMED && we && ctrl_hit && wbyte == ON_CODE) |=> lock);
    // R3
    lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KEY_ARMED && we && ctrl_hit && wbyte == OFF_CODE) |=> !lock);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KEY_IDLE) |=> $stable(lock));
    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ctrl_hit && wbyte != ON_CODE && wbyte != OFF_CODE)
        |=> ($stable(lock) && state == KEY_IDLE));
endmodule

// File: rtl/write_pipe.sv
module write_pipe #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 28,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [DATA_W-1:0] push_data,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data
);
    logic              vld [STAGES];
    logic [IDX_W-1:0]  idx [STAGES];
    logic [DATA_W-1:0] dat [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld[0] <= 1'b0;
            idx[0] <= '0;
            dat[0] <= '0;
        end else if (push) begin
            vld[0] <= 1'b1;
            idx[0] <= push_idx;
            dat[0] <= push_data;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[s] <= 1'b0;
                idx[s] <= '0;
                dat[s] <= '0;
            end else if (push) begin
                vld[s] <= vld[s-1];
                idx[s] <= idx[s-1];
                dat[s] <= dat[s-1];
            end
        end
    end

    assign commit      = push && vld[STAGES-1];
    assign commit_idx  = idx[STAGES-1];
    assign commit_data = dat[STAGES-1];

    // R8
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (vld[0] && idx[0] == $past(push_idx) && dat[0] == $past(push_data)));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> ($stable(vld[STAGES-1]) && $stable(dat[STAGES-1]) && $stable(idx[STAGES-1])));
endmodule

// File: rtl/reg_store.sv
module reg_store #(
    parameter int DEPTH  = 63,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic              rhit,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= rhit ? mem[ridx] : '0;
    end

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: rtl/keyreg_ram.sv
module keyreg_ram #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 28,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4380,
    parameter logic [ADDR_W-1:0] WIN_LAST  = 16'h43BE,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'hE7FE,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hE7E3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              lock_on
);
    localparam int DEPTH = int'(WIN_LAST) - int'(WIN_BASE) + 1;
    localparam int IDX_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] offset;
    logic              win_hit;
    logic [IDX_W-1:0]  win_idx;
    logic              accept;
    logic              cm_en;
    logic [IDX_W-1:0]  cm_idx;
    logic [DATA_W-1:0] cm_data;

    assign offset  = bus_addr - WIN_BASE;
    assign win_hit = (offset < ADDR_W'(DEPTH));
    assign win_idx = offset[IDX_W-1:0];
    assign accept  = wr_en && win_hit && !lock_on;

    key_detect #(
        .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(bus_addr),
        .wbyte(bus_wdata[7:0]), .lock(lock_on)
    );

    write_pipe #(.IDX_W(IDX_W), .DATA_W(DATA_W), .STAGES(2)) u_pipe (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_idx(win_idx),
        .push_data(bus_wdata), .commit(cm_en), .commit_idx(cm_idx),
        .commit_data(cm_data)
    );

    reg_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cm_en), .widx(cm_idx), .wdata(cm_data),
        .re(rd_en), .rhit(win_hit), .ridx(win_idx), .rdata(rd_data)
    );

    // R10
    out_win_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !win_hit) |=> (rd_data == '0));
    // R6
    locked_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock_on) |-> !cm_en);
endmodule

// File: tb/keyreg_ram_tb.sv
module keyreg_ram_tb;
    localparam logic [15:0] BASE = 16'h4380;
    localparam int          NWIN = 63;
    localparam logic [15:0] KADDR = 16'hE7FE;
    localparam logic [15:0] CADDR = 16'hE7E3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [27:0] bus_wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [27:0] rd_data;
    logic        lock_on;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [27:0] m_mem [NWIN];
    logic        m_vld [2];
    logic [5:0]  m_idx [2];
    logic [27:0] m_dat [2];
    logic        m_lock;
    logic        m_armed;

    always #2.5 clk = ~clk;

    keyreg_ram u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .lock_on(lock_on)
    );

    function automatic bit in_win(logic [15:0] a);
        return (a >= BASE) && (a < BASE + 16'(NWIN));
    endfunction

    function automatic logic [27:0] exp_read(logic [15:0] a);
        return in_win(a) ? m_mem[a - BASE] : 28'd0;
    endfunction

    task automatic check(string tag, logic [27:0] act, logic [27:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(logic [15:0] a, logic [27:0] d);
        if (in_win(a) && !m_lock) begin
            if (m_vld[1]) m_mem[m_idx[1]] = m_dat[1];
            m_vld[1] = m_vld[0]; m_idx[1] = m_idx[0]; m_dat[1] = m_dat[0];
            m_vld[0] = 1'b1; m_idx[0] = 6'(a - BASE); m_dat[0] = d;
        end
        if (m_armed && a == CADDR) begin
            if (d[7:0] == 8'h80)      m_lock = 1'b1;
            else if (d[7:0] == 8'h00) m_lock = 1'b0;
        end
        m_armed = (a == KADDR) && (d[7:0] == 8'hAD);
    endtask

    task automatic do_write(logic [15:0] a, logic [27:0] d, string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check(tag, 28'(lock_on), 28'(m_lock));
    endtask

    task automatic do_read(logic [15:0] a, string tag);
        logic [27:0] exp;
        @(negedge clk);
        bus_addr = a; rd_en = 1'b1; wr_en = 1'b0;
        exp = exp_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NWIN; i++) m_mem[i] = '0;
        for (int i = 0; i < 2; i++) begin m_vld[i] = 0; m_idx[i] = '0; m_dat[i] = '0; end
        m_lock = 0; m_armed = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1", 28'(lock_on), 28'd0);
        for (int i = 0; i < NWIN; i++) do_read(BASE + 16'(i), "R1");
        // R10: outside window
        do_read(16'h437F, "R10");
        do_read(16'h43BF, "R10");

        // R8 / R9: pipeline commit timing
        do_write(BASE + 16'd0, 28'hAAAAAAA, "R8");
        do_write(BASE + 16'd1, 28'hBBBBBBB, "R8");
        do_read(BASE + 16'd0, "R9");
        check("R9", rd_data, 28'd0);
        do_write(BASE + 16'd2, 28'hCCCCCCC, "R8");
        do_read(BASE + 16'd0, "R8");
        check("R8", rd_data, 28'hAAAAAAA);
        do_read(BASE + 16'd1, "R9");

        // R11: outside writes do not advance pipeline
        do_write(16'h1234, 28'h5555555, "R11");
        do_read(BASE + 16'd1, "R11");
        check("R11", rd_data, 28'd0);

        // R2: lock
        do_write(KADDR, 28'h00000AD, "R2");
        do_write(CADDR, 28'h0000080, "R2");
        check("R2", 28'(lock_on), 28'd1);
        // R6: locked writes dropped, pipeline frozen
        do_write(BASE + 16'd3, 28'h3333333, "R6");
        do_write(BASE + 16'd4, 28'h4444444, "R6");
        do_write(BASE + 16'd5, 28'h6666666, "R6");
        do_read(BASE + 16'd1, "R6");
        check("R6", rd_data, 28'd0);
        // R7: reads under lock
        do_read(BASE + 16'd0, "R7");
        // R5: bad code
        do_write(KADDR, 28'h00000AD, "R5");
        do_write(CADDR, 28'h0000055, "R5");
        do_write(CADDR, 28'h0000000, "R5");
        check("R5", 28'(lock_on), 28'd1);
        // R4: interleaved write disarms
        do_write(KADDR, 28'h00000AD, "R4");
        do_write(16'h0100, 28'h0, "R4");
        do_write(CADDR, 28'h0000000, "R4");
        check("R4", 28'(lock_on), 28'd1);
        // R3: unlock
        do_write(KADDR, 28'h00000AD, "R3");
        do_write(CADDR, 28'h0000000, "R3");
        check("R3", 28'(lock_on), 28'd0);
        do_write(BASE + 16'd62, 28'h7777777, "R6");
        do_read(BASE + 16'd1, "R6");
        check("R6", rd_data, 28'hBBBBBBB);
        do_read(BASE + 16'd3, "R6");

        // random phase
        for (int n = 0; n < 1500; n++) begin
            int r;
            logic [15:0] a;
            logic [27:0] d;
            r = int'($urandom % 10);
            a = BASE + 16'($urandom % NWIN);
            d = 28'($urandom);
            if ($urandom % 16 == 0) a = ($urandom % 2) ? 16'h437F : 16'h43BF;
            if (r < 5)       do_write(a, d, "R8");
            else if (r < 7)  do_read(a, "R7");
            else if (r == 7) do_write(KADDR, {20'($urandom), 8'hAD}, "R4");
            else if (r == 8) begin
                case ($urandom % 3)
                    0: d[7:0] = 8'h80;
                    1: d[7:0] = 8'h00;
                    default: ;
                endcase
                do_write(CADDR, d, "R5");
            end else begin
                do_write(KADDR, 28'h00000AD, "R2");
                do_write(CADDR, ($urandom % 2) ? 28'h0000080 : 28'h0000000, "R3");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule